// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the four interrupt sources of a FIFO-mode UART into one interrupt request line and a 4-bit identification code. The sources are receiver line errors, receive data at or above the trigger level, receive timeout and transmit holding empty. When several sources are active, the code reports the one with the highest priority. Bit 0 of the code is set only when nothing is pending, so software can poll that bit.

The receive-side sources come straight from their inputs. The surrounding FIFO logic provides the receive level, the trigger level, a sticky line-error flag and a timeout flag. Only the transmit-empty source holds state of its own. It watches the transmit FIFO level and becomes pending when the FIFO drains. The delay before it becomes pending depends on the FIFO's recent occupancy: if two or more bytes have been in the FIFO at once since the last empty event, it becomes pending at once; otherwise it waits one character time less the final stop bit. The block measures that time in 16x baud ticks. A write to the transmit holding register clears the source. Reading the identification code also clears it, but only while it is the source being reported.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq` is 0 and `iid` is 4'h1.
- R2: When `fifo_en`, `ien_ls` and `line_err` are all 1, `iid` is 4'h6, whatever the other sources are doing.
- R3: When `fifo_en` and `ien_rx` are 1, `rx_level >= rx_trig`, and line status is not active, `iid` is 4'h4. The source drops in the same cycle that `rx_level` falls below `rx_trig`.
- R4: When `fifo_en`, `ien_rx` and `tmo_flag` are 1 and no higher source is active, `iid` is 4'hC. Timeout ranks below data-available and above transmit-empty.
- R5: A pending transmit-empty source reports `iid` 4'h2 only when `fifo_en` and `ien_tx` are 1 and no other source is active.
- R6: If `tx_level` reaches 0 and at least two bytes have been in the transmit FIFO at once since the last empty event, transmit-empty is pending after the same clock edge.
- R7: If `tx_level` reaches 0 without that two-byte condition, transmit-empty becomes pending on the `char_bits`*16-th `baud_tick` after the edge that saw the FIFO empty, and not before.
- R8: A `thr_wr` pulse clears pending transmit-empty and cancels a delay in progress.
- R9: An `iir_rd` pulse clears transmit-empty only when `iid` is 4'h2 in that cycle. Otherwise it has no effect on the source.
- R10: A change of `fifo_en` while `tx_level` is 0 makes transmit-empty pending after that edge, with no delay.
- R11: When `fifo_en` is 0, `irq` is 0 and `iid` is 4'h1.
- R12: `irq` is 1 exactly when at least one enabled source is active, and `iid[0]` equals the inverse of `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enable; gates all sources |
| ien_ls | input | 1 | Line status source enable |
| ien_rx | input | 1 | Receive data and timeout enable |
| ien_tx | input | 1 | Transmit-empty enable |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| rx_trig | input | LVL_W | Programmed receive trigger level |
| line_err | input | 1 | Sticky receive line error flag |
| tmo_flag | input | 1 | Receive timeout flag from the external timer |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| baud_tick | input | 1 | 16x baud rate strobe |
| char_bits | input | CB_W | Bits per character, not counting the final stop bit |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rbr_rd | input | 1 | Receive buffer read strobe (timing reference only) |
| iir_rd | input | 1 | Identification register read strobe |
| irq | output | 1 | Interrupt request |
| iid | output | 4 | Interrupt identification code |

## Verification
Random vectors vary the receive inputs, the enables and the FIFO mode bit while the transmit source is held idle. Comparing each of them against the priority function shows whether the ranking of line status, data-available and timeout is correct, and whether every gate is respected. Directed sequences drain the transmit FIFO in three ways: after a multi-byte burst, after a single byte, and through a FIFO-mode toggle. These tell the immediate path apart from the delayed path and pin the delay to an exact tick count. Reads of the identification code are issued while transmit-empty is reported and while line status masks it, which separates a read that clears the source from one that is ignored.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_NONE = 4'h1,
    IID_THRE = 4'h2,
    IID_RDA  = 4'h4,
    IID_LSR  = 4'h6,
    IID_TMO  = 4'hC
  } iid_e;

  typedef struct packed {
    logic lsr;
    logic rda;
    logic tmo;
    logic thre;
  } src_t;

endpackage

// File: rtl/uart_irq_txempty.sv
module uart_irq_txempty #(
  parameter int LVL_W = 5,
  parameter int CB_W  = 4,
  parameter int TPB   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             baud_tick,
  input  logic [CB_W-1:0]  char_bits,
  input  logic             thr_wr,
  input  logic             iir_clr,
  output logic             pend
);

  localparam int DLY_W = CB_W + $clog2(TPB);

  logic             pend_q, pend_d;
  logic             seen2_q, seen2_d;
  logic             prev_empty_q;
  logic             fe_q;
  logic             dly_on_q, dly_on_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  logic             tx_empty, empty_edge, fe_chg;
  logic             set_now, start_dly, fire;
  logic [DLY_W-1:0] load_val;

  assign load_val   = DLY_W'(char_bits) * DLY_W'(TPB);
  assign tx_empty   = (tx_level == '0);
  assign empty_edge = tx_empty && !prev_empty_q;
  assign fe_chg     = (fifo_en != fe_q);
  assign set_now    = tx_empty && (fe_chg || (empty_edge && (seen2_q || load_val == '0)));
  assign start_dly  = empty_edge && !seen2_q && (load_val != '0) && !fe_chg;
  assign fire       = dly_on_q && baud_tick && (cnt_q == DLY_W'(1)) && tx_empty;

  always_comb begin
    pend_d = pend_q;
    if (set_now || fire) pend_d = 1'b1;
    if (thr_wr || iir_clr) pend_d = 1'b0;
  end

  always_comb begin
    dly_on_d = dly_on_q;
    cnt_d    = cnt_q;
    if (thr_wr || !tx_empty || set_now) begin
      dly_on_d = 1'b0;
    end else if (start_dly) begin
      dly_on_d = 1'b1;
      cnt_d    = load_val;
    end else if (dly_on_q && baud_tick) begin
      if (cnt_q == DLY_W'(1)) dly_on_d = 1'b0;
      cnt_d = cnt_q - DLY_W'(1);
    end
  end

  always_comb begin
    seen2_d = seen2_q;
    if (tx_level >= LVL_W'(2)) seen2_d = 1'b1;
    else if (pend_d && !pend_q) seen2_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      seen2_q      <= 1'b0;
      prev_empty_q <= 1'b1;
      fe_q         <= 1'b0;
      dly_on_q     <= 1'b0;
      cnt_q        <= '0;
    end else begin
      pend_q       <= pend_d;
      seen2_q      <= seen2_d;
      prev_empty_q <= tx_empty;
      fe_q         <= fifo_en;
      dly_on_q     <= dly_on_d;
      cnt_q        <= cnt_d;
    end
  end

  assign pend = pend_q;

  // R8
  wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !pend_q);
  // R6
  rise_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(tx_level) == '0));
  // R7
  no_delay_when_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !$past(thr_wr)) |-> !dly_on_q || !$rose(pend_q));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_t act,
  output iid_e code
);

  always_comb begin
    if (act.lsr)       code = IID_LSR;
    else if (act.rda)  code = IID_RDA;
    else if (act.tmo)  code = IID_TMO;
    else if (act.thre) code = IID_THRE;
    else               code = IID_NONE;
  end

  // R2
  lsr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.lsr |-> code == IID_LSR);
  // R12
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> code == IID_NONE);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int CB_W  = 4,
  parameter int TPB   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             ien_ls,
  input  logic             ien_rx,
  input  logic             ien_tx,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             line_err,
  input  logic             tmo_flag,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             baud_tick,
  input  logic [CB_W-1:0]  char_bits,
  input  logic             thr_wr,
  input  logic             rbr_rd,
  input  logic             iir_rd,
  output logic             irq,
  output logic [3:0]       iid
);

  src_t act;
  iid_e code;
  logic thre_pend;
  logic iir_clr;
  logic rd_unused;

  assign rd_unused = rbr_rd;

  assign act.lsr  = fifo_en && ien_ls && line_err;
  assign act.rda  = fifo_en && ien_rx && (rx_level >= rx_trig);
  assign act.tmo  = fifo_en && ien_rx && tmo_flag;
  assign act.thre = fifo_en && ien_tx && thre_pend;

  assign iir_clr = iir_rd && (code == IID_THRE);

  uart_irq_txempty #(.LVL_W(LVL_W), .CB_W(CB_W), .TPB(TPB)) u_txe (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .tx_level  (tx_level),
    .baud_tick (baud_tick),
    .char_bits (char_bits),
    .thr_wr    (thr_wr),
    .iir_clr   (iir_clr),
    .pend      (thre_pend)
  );

  uart_irq_prio u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .code  (code)
  );

  assign irq = |act;
  assign iid = code;

  // R11
  fifo_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !irq);
  // R12
  irq_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !iid[0]);

endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;

  localparam int LVL_W = 5;
  localparam int CB_W  = 4;

  logic clk, rst_n;
  logic fifo_en, ien_ls, ien_rx, ien_tx, line_err, tmo_flag;
  logic [LVL_W-1:0] rx_level, rx_trig, tx_level;
  logic baud_tick, thr_wr, rbr_rd, iir_rd;
  logic [CB_W-1:0] char_bits;
  logic irq;
  logic [3:0] iid;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  uart_irq_ident #(.LVL_W(LVL_W), .CB_W(CB_W), .TPB(16)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ien_ls(ien_ls),
    .ien_rx(ien_rx), .ien_tx(ien_tx), .rx_level(rx_level), .rx_trig(rx_trig),
    .line_err(line_err), .tmo_flag(tmo_flag), .tx_level(tx_level),
    .baud_tick(baud_tick), .char_bits(char_bits), .thr_wr(thr_wr),
    .rbr_rd(rbr_rd), .iir_rd(iir_rd), .irq(irq), .iid(iid)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [4:0] exp_out(logic fe, logic els, logic erx, logic etx,
                                         logic le, logic [LVL_W-1:0] lvl,
                                         logic [LVL_W-1:0] trg, logic tmo, logic tp);
    if (!fe)               return {1'b0, 4'h1};
    if (els && le)         return {1'b1, 4'h6};
    if (erx && lvl >= trg) return {1'b1, 4'h4};
    if (erx && tmo)        return {1'b1, 4'hC};
    if (etx && tp)         return {1'b1, 4'h2};
    return {1'b0, 4'h1};
  endfunction

  task automatic chk(string req, logic [4:0] exp);
    vectors++;
    if ({irq, iid} !== exp) begin
      fails++;
      $display("FAIL %s: irq/iid actual %b/%h expected %b/%h", req, irq, iid, exp[4], exp[3:0]);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; fifo_en = 0; ien_ls = 0; ien_rx = 0; ien_tx = 0;
    line_err = 0; tmo_flag = 0; rx_level = 0; rx_trig = 5'd8;
    tx_level = 5'd5; baud_tick = 0; char_bits = 4'd2;
    thr_wr = 0; rbr_rd = 0; iir_rd = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1", {1'b0, 4'h1});

    // Random phase over receive sources; transmit source idle (R2 R3 R4 R11 R12)
    for (int i = 0; i < 400; i++) begin
      fifo_en  = ($urandom % 8) != 0;
      ien_ls   = $urandom;
      ien_rx   = $urandom;
      ien_tx   = $urandom;
      line_err = ($urandom % 3) == 0;
      tmo_flag = $urandom;
      rx_level = LVL_W'($urandom % 17);
      rx_trig  = LVL_W'(1 + $urandom % 16);
      rbr_rd   = $urandom;
      iir_rd   = $urandom;
      #1;
      chk("R2/R3/R4/R11/R12 random", exp_out(fifo_en, ien_ls, ien_rx, ien_tx,
          line_err, rx_level, rx_trig, tmo_flag, 1'b0));
      cyc(1);
    end
    iir_rd = 0; rbr_rd = 0;

    // R3 boundary: level equal to trigger, then one below
    fifo_en = 1; ien_ls = 0; ien_rx = 1; ien_tx = 0; line_err = 0; tmo_flag = 0;
    rx_trig = 5'd4; rx_level = 5'd4; #1;
    chk("R3 at trigger", {1'b1, 4'h4});
    rx_level = 5'd3; #1;
    chk("R3 below trigger", {1'b0, 4'h1});

    // Transmit side
    ien_rx = 0; ien_tx = 1; rx_level = 0;
    cyc(1);
    // R6: burst of 3 bytes then empty -> immediate
    tx_level = 5'd3; cyc(1);
    tx_level = 5'd0; cyc(1);
    chk("R6 immediate after burst", {1'b1, 4'h2});

    // R9: identification read while 02h reported clears it
    iir_rd = 1; cyc(1); iir_rd = 0;
    chk("R9 read clears", {1'b0, 4'h1});

    // R7: single byte then empty -> delay of char_bits*16 ticks
    tx_level = 5'd1; cyc(1);
    tx_level = 5'd0; baud_tick = 1; char_bits = 4'd2;
    cyc(1);
    cyc(31);
    chk("R7 not before last tick", {1'b0, 4'h1});
    cyc(1);
    chk("R7 on last tick", {1'b1, 4'h2});
    baud_tick = 0;

    // R8: write clears
    thr_wr = 1; cyc(1); thr_wr = 0;
    chk("R8 write clears", {1'b0, 4'h1});
    // R8: write cancels running delay
    tx_level = 5'd1; cyc(1);
    tx_level = 5'd0; cyc(1);
    baud_tick = 1; cyc(5);
    thr_wr = 1; cyc(1); thr_wr = 0;
    cyc(40);
    chk("R8 delay cancelled", {1'b0, 4'h1});
    baud_tick = 0;

    // R10: FIFO enable change while empty
    fifo_en = 0; cyc(1);
    chk("R11 fifo off masks", {1'b0, 4'h1});
    fifo_en = 1; cyc(1);
    chk("R10 immediate on fifo_en change", {1'b1, 4'h2});

    // R5: gate by ien_tx
    ien_tx = 0; #1;
    chk("R5 disabled", {1'b0, 4'h1});
    ien_tx = 1; #1;
    chk("R5 enabled", {1'b1, 4'h2});

    // R4: timeout ranks above transmit empty
    ien_rx = 1; rx_trig = 5'd8; tmo_flag = 1; #1;
    chk("R4 timeout over thre", {1'b1, 4'hC});
    tmo_flag = 0; ien_rx = 0; #1;

    // R9: read while line status reported leaves transmit empty
    ien_ls = 1; line_err = 1; #1;
    chk("R2 line status over thre", {1'b1, 4'h6});
    iir_rd = 1; cyc(1); iir_rd = 0;
    line_err = 0; #1;
    chk("R9 masked read ignored", {1'b1, 4'h2});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule